// File: doc/BRIEF.md
# 16-bit ModRM Operand Decoder

This block turns the bytes that follow an opcode into two operand descriptors. The opcode decoder upstream has already pulled out the direction, width and sign-extension bits. It has also settled whether a ModRM byte is present, whether its reg field names an operand, and whether immediate data follows and may be two bytes wide. It passes all of this in one request handshake. The block then takes bytes one at a time from a valid/ready stream: first the ModRM byte, then any displacement, then any immediate.

When the last byte has been taken, the block raises a result valid. With it come two operand slots and the number of bytes consumed. Slot 0 is the destination and slot 1 is the source. Each slot describes one of three things: a register, given as its index plus a high-byte flag and a width; a memory operand, given as a base/index pair with a signed 16-bit displacement; or an immediate value. The result stays on the outputs until the consumer accepts it. The block takes no new request and no new byte before that.

Top module: `modrm_dec`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `in_ready`=0, `res_valid`=0, and both slots read kind 0 (none) with every field zero. A reset in the middle of an instruction returns the block to this state.
- R2: When mod=11, the rm field names a register operand with kind 1, and its width flag equals W.
- R3: Register numbering. With W=1, index 0..7 gives reg id 0..7 (AX,CX,DX,BX,SP,BP,SI,DI) with hi=0. With W=0, index 0..3 gives AL..BL, reported as reg id 0..3 with hi=0, and index 4..7 gives AH..BH, reported as reg id 0..3 with hi=1.
- R4: When D=1, the reg-field operand is in slot 0 and the rm operand is in slot 1. When D=0, the two swap. If the reg field is not an operand, its slot stays empty.
- R5: When mod=00 and rm=110, the operand is memory (kind 2) with base 0 (none) and index 0 (none). Two displacement bytes follow, and the value is assembled low byte first.
- R6: When mod=01, one displacement byte follows and is sign-extended to 16 bits. When mod=10, two bytes follow, low byte first. When mod=00 (other than rm=110), no displacement byte follows and the displacement is 0.
- R7: For a memory operand, rm 0..7 gives (base,index) = (BX,SI),(BX,DI),(BP,SI),(BP,DI),(-,SI),(-,DI),(BP,-),(BX,-). The base is coded 0 none, 1 BX, 2 BP. The index is coded 0 none, 1 SI, 2 DI.
- R8: The immediate is two bytes, low byte first, with width flag 1, only when wide data is allowed, W=1 and S=0. Otherwise it is one byte with width flag 0: sign-extended when S=1 and zero-extended when S=0. The immediate has kind 3.
- R9: All displacement bytes are taken before the immediate bytes. The immediate goes into slot 0 if that slot is empty, and into slot 1 otherwise.
- R10: `res_len` equals the number of bytes taken for the instruction (at most 5). While `res_valid` is high and `res_ready` is low, the result holds still, and both `in_ready` and `req_ready` stay low.
- R11: With no ModRM byte, an immediate lands in slot 0. With neither a ModRM byte nor data, the result is ready one cycle after the request, with `res_len`=0 and both slots empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Opcode fields valid |
| req_ready | output | 1 | Block idle, takes the fields |
| req_dir | input | 1 | Direction bit: reg operand goes to slot 0 when set |
| req_wide | input | 1 | Width bit W |
| req_sext | input | 1 | Sign-extend bit S |
| req_has_modrm | input | 1 | A ModRM byte follows |
| req_reg_is_opnd | input | 1 | The reg field names an operand |
| req_has_data | input | 1 | Immediate data follows |
| req_data_wide_ok | input | 1 | Opcode permits a two-byte immediate |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Block takes a stream byte |
| in_byte | input | 8 | Stream byte |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_len | output | 3 | Bytes consumed |
| s0_kind | output | 2 | Slot 0 kind: 0 none, 1 reg, 2 mem, 3 imm |
| s0_reg | output | 3 | Slot 0 register id |
| s0_hi | output | 1 | Slot 0 high-byte flag |
| s0_wide | output | 1 | Slot 0 16-bit flag |
| s0_base | output | 2 | Slot 0 base register |
| s0_index | output | 2 | Slot 0 index register |
| s0_value | output | 16 | Slot 0 displacement or immediate |
| s1_kind | output | 2 | Slot 1 kind |
| s1_reg | output | 3 | Slot 1 register id |
| s1_hi | output | 1 | Slot 1 high-byte flag |
| s1_wide | output | 1 | Slot 1 16-bit flag |
| s1_base | output | 2 | Slot 1 base register |
| s1_index | output | 2 | Slot 1 index register |
| s1_value | output | 16 | Slot 1 displacement or immediate |

## Verification
The assertions watch the handshake rules on every cycle. A pending result must hold steady and block both inputs. The byte count may never exceed five. A request with neither ModRM nor data must finish at once with a count of zero. Two more hold whenever a result is out: the reg operand sits in the slot the direction bit picks, and a direct address carries no base or index register. The exact register numbering, the base/index pairs, and the sign- or zero-extension of displacements and immediates are values, and only the bench's scenarios can show them. The same goes for low-byte-first assembly and for the immediate landing in the free slot.

// File: rtl/modrm_dec_pkg.sv
package modrm_dec_pkg;

  localparam logic [1:0] K_NONE = 2'd0;
  localparam logic [1:0] K_REG  = 2'd1;
  localparam logic [1:0] K_MEM  = 2'd2;
  localparam logic [1:0] K_IMM  = 2'd3;

  localparam logic [1:0] B_NONE = 2'd0;
  localparam logic [1:0] B_BX   = 2'd1;
  localparam logic [1:0] B_BP   = 2'd2;
  localparam logic [1:0] X_NONE = 2'd0;
  localparam logic [1:0] X_SI   = 2'd1;
  localparam logic [1:0] X_DI   = 2'd2;

  localparam int BYTE_W  = 8;
  localparam int VALUE_W = 2 * BYTE_W;
  localparam int LEN_W   = 3;

  typedef struct packed {
    logic d;
    logic w;
    logic s;
    logic has_modrm;
    logic reg_opnd;
    logic has_data;
    logic wide_ok;
  } cfg_t;

  typedef struct packed {
    logic [1:0]         kind;
    logic [2:0]         reg_id;
    logic               hi;
    logic               wide;
    logic [1:0]         base;
    logic [1:0]         idx;
    logic [VALUE_W-1:0] value;
  } slot_t;

  // displacement byte count implied by mod/rm
  function automatic logic [1:0] disp_count(logic [1:0] md, logic [2:0] rm);
    case (md)
      2'b00:   disp_count = (rm == 3'b110) ? 2'd2 : 2'd0;
      2'b01:   disp_count = 2'd1;
      2'b10:   disp_count = 2'd2;
      default: disp_count = 2'd0;
    endcase
  endfunction

  function automatic logic [VALUE_W-1:0] sext8(logic [BYTE_W-1:0] b);
    sext8 = {{BYTE_W{b[BYTE_W-1]}}, b};
  endfunction

  function automatic logic imm_is_wide(cfg_t c);
    imm_is_wide = c.wide_ok & c.w & ~c.s;
  endfunction

  function automatic slot_t reg_slot(logic [2:0] n, logic w);
    slot_t r;
    r        = '0;
    r.kind   = K_REG;
    r.wide   = w;
    r.reg_id = w ? n : {1'b0, n[1:0]};
    r.hi     = ~w & n[2];
    reg_slot = r;
  endfunction

  function automatic slot_t mem_slot(logic [1:0] md, logic [2:0] rm, logic w,
                                     logic [VALUE_W-1:0] disp);
    slot_t r;
    r       = '0;
    r.kind  = K_MEM;
    r.wide  = w;
    r.value = disp;
    case (rm)
      3'd0, 3'd1, 3'd7: r.base = B_BX;
      3'd2, 3'd3:       r.base = B_BP;
      3'd6:             r.base = (md == 2'b00) ? B_NONE : B_BP;
      default:          r.base = B_NONE;
    endcase
    case (rm)
      3'd0, 3'd2, 3'd4: r.idx = X_SI;
      3'd1, 3'd3, 3'd5: r.idx = X_DI;
      default:          r.idx = X_NONE;
    endcase
    mem_slot = r;
  endfunction

endpackage

// File: rtl/modrm_seq.sv
module modrm_seq
  import modrm_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  cfg_t               cfg_in,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BYTE_W-1:0]  in_byte,
  output logic               res_valid,
  input  logic               res_ready,
  output cfg_t               cfg_q,
  output logic [BYTE_W-1:0]  modrm_q,
  output logic [VALUE_W-1:0] disp_q,
  output logic [VALUE_W-1:0] imm_q,
  output logic [LEN_W-1:0]   len_q
);

  typedef enum logic [2:0] {S_IDLE, S_MODRM, S_DISP0, S_DISP1, S_IMM0, S_IMM1, S_DONE} st_e;
  st_e        st_q;
  logic [1:0] dcnt_q;

  // named events
  logic req_take, byte_take, res_take;
  logic [1:0] dcnt_now;
  st_e        after_disp;

  assign req_ready = (st_q == S_IDLE);
  assign in_ready  = (st_q == S_MODRM) || (st_q == S_DISP0) || (st_q == S_DISP1) ||
                     (st_q == S_IMM0)  || (st_q == S_IMM1);
  assign res_valid = (st_q == S_DONE);
  assign req_take  = req_valid & req_ready;
  assign byte_take = in_valid & in_ready;
  assign res_take  = res_valid & res_ready;
  assign dcnt_now  = disp_count(in_byte[7:6], in_byte[2:0]);
  assign after_disp = cfg_q.has_data ? S_IMM0 : S_DONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cfg_q   <= '0;
      modrm_q <= '0;
      disp_q  <= '0;
      imm_q   <= '0;
      len_q   <= '0;
      dcnt_q  <= '0;
    end else begin
      if (byte_take) len_q <= len_q + 1'b1;
      case (st_q)
        S_IDLE: if (req_take) begin
          cfg_q   <= cfg_in;
          modrm_q <= '0;
          disp_q  <= '0;
          imm_q   <= '0;
          len_q   <= '0;
          st_q    <= cfg_in.has_modrm ? S_MODRM : (cfg_in.has_data ? S_IMM0 : S_DONE);
        end
        S_MODRM: if (byte_take) begin
          modrm_q <= in_byte;
          dcnt_q  <= dcnt_now;
          st_q    <= (dcnt_now != 2'd0) ? S_DISP0 : after_disp;
        end
        S_DISP0: if (byte_take) begin
          disp_q <= (dcnt_q == 2'd1) ? sext8(in_byte) : {{BYTE_W{1'b0}}, in_byte};
          st_q   <= (dcnt_q == 2'd2) ? S_DISP1 : after_disp;
        end
        S_DISP1: if (byte_take) begin
          disp_q[VALUE_W-1:BYTE_W] <= in_byte;
          st_q <= after_disp;
        end
        S_IMM0: if (byte_take) begin
          imm_q <= cfg_q.s ? sext8(in_byte) : {{BYTE_W{1'b0}}, in_byte};
          st_q  <= imm_is_wide(cfg_q) ? S_IMM1 : S_DONE;
        end
        S_IMM1: if (byte_take) begin
          imm_q[VALUE_W-1:BYTE_W] <= in_byte;
          st_q <= S_DONE;
        end
        S_DONE: if (res_take) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(len_q) && $stable(disp_q) && $stable(imm_q));

  // R10
  pending_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready && !req_ready);

  // R10
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> len_q <= 3'd5);

  // R11
  empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_take && !cfg_in.has_modrm && !cfg_in.has_data |=> res_valid && len_q == 3'd0);

endmodule

// File: rtl/modrm_map.sv
module modrm_map
  import modrm_dec_pkg::*;
(
  input  cfg_t               cfg,
  input  logic [BYTE_W-1:0]  modrm,
  input  logic [VALUE_W-1:0] disp,
  input  logic [VALUE_W-1:0] imm,
  output slot_t              slot0,
  output slot_t              slot1
);

  slot_t reg_s, rm_s, imm_s;
  logic [1:0] md;

  assign md = modrm[7:6];

  always_comb begin
    reg_s = reg_slot(modrm[5:3], cfg.w);
    rm_s  = (md == 2'b11) ? reg_slot(modrm[2:0], cfg.w)
                          : mem_slot(md, modrm[2:0], cfg.w, disp);
    imm_s       = '0;
    imm_s.kind  = K_IMM;
    imm_s.wide  = imm_is_wide(cfg);
    imm_s.value = imm;

    slot0 = '0;
    slot1 = '0;
    if (cfg.has_modrm) begin
      if (cfg.d) begin
        if (cfg.reg_opnd) slot0 = reg_s;
        slot1 = rm_s;
      end else begin
        slot0 = rm_s;
        if (cfg.reg_opnd) slot1 = reg_s;
      end
    end
    if (cfg.has_data) begin
      if (slot0.kind == K_NONE) slot0 = imm_s;
      else                      slot1 = imm_s;
    end
  end

endmodule

// File: rtl/modrm_dec.sv
module modrm_dec
  import modrm_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_dir,
  input  logic        req_wide,
  input  logic        req_sext,
  input  logic        req_has_modrm,
  input  logic        req_reg_is_opnd,
  input  logic        req_has_data,
  input  logic        req_data_wide_ok,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_byte,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [2:0]  res_len,
  output logic [1:0]  s0_kind,
  output logic [2:0]  s0_reg,
  output logic        s0_hi,
  output logic        s0_wide,
  output logic [1:0]  s0_base,
  output logic [1:0]  s0_index,
  output logic [15:0] s0_value,
  output logic [1:0]  s1_kind,
  output logic [2:0]  s1_reg,
  output logic        s1_hi,
  output logic        s1_wide,
  output logic [1:0]  s1_base,
  output logic [1:0]  s1_index,
  output logic [15:0] s1_value
);

  cfg_t               cfg_in, cfg_q;
  logic [BYTE_W-1:0]  modrm_q;
  logic [VALUE_W-1:0] disp_q, imm_q;
  slot_t              m0, m1, o0, o1;

  assign cfg_in = '{d: req_dir, w: req_wide, s: req_sext, has_modrm: req_has_modrm,
                    reg_opnd: req_reg_is_opnd, has_data: req_has_data,
                    wide_ok: req_data_wide_ok};

  modrm_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .cfg_in(cfg_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .res_valid(res_valid), .res_ready(res_ready),
    .cfg_q(cfg_q), .modrm_q(modrm_q), .disp_q(disp_q), .imm_q(imm_q), .len_q(res_len)
  );

  modrm_map u_map (
    .cfg(cfg_q), .modrm(modrm_q), .disp(disp_q), .imm(imm_q),
    .slot0(m0), .slot1(m1)
  );

  // slots read empty unless a result is presented
  assign o0 = res_valid ? m0 : '0;
  assign o1 = res_valid ? m1 : '0;

  assign {s0_kind, s0_reg, s0_hi, s0_wide, s0_base, s0_index, s0_value} = o0;
  assign {s1_kind, s1_reg, s1_hi, s1_wide, s1_base, s1_index, s1_value} = o1;

  // named observation wires for the checks below
  logic direct_addr, reg_in_s0, reg_in_s1;
  slot_t rm_seen;
  assign direct_addr = cfg_q.has_modrm && modrm_q[7:6] == 2'b00 && modrm_q[2:0] == 3'b110;
  assign rm_seen     = cfg_q.d ? o1 : o0;
  assign reg_in_s0   = cfg_q.has_modrm && cfg_q.reg_opnd && cfg_q.d;
  assign reg_in_s1   = cfg_q.has_modrm && cfg_q.reg_opnd && !cfg_q.d;

  // R4
  dir_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && reg_in_s0 |-> s0_kind == K_REG);

  // R4
  dir_slot1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && reg_in_s1 && !cfg_q.has_data |-> s1_kind == K_REG);

  // R5
  direct_no_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && direct_addr |-> rm_seen.kind == K_MEM && rm_seen.base == B_NONE && rm_seen.idx == X_NONE);

  // R1
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> s0_kind == K_NONE && s1_kind == K_NONE);

endmodule

// File: tb/modrm_dec_bench.sv
module modrm_dec_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic req_valid, req_ready, req_dir, req_wide, req_sext, req_has_modrm;
  logic req_reg_is_opnd, req_has_data, req_data_wide_ok;
  logic in_valid, in_ready;
  logic [7:0] in_byte;
  logic res_valid, res_ready;
  logic [2:0] res_len;
  logic [1:0] s0_kind, s0_base, s0_index, s1_kind, s1_base, s1_index;
  logic [2:0] s0_reg, s1_reg;
  logic s0_hi, s0_wide, s1_hi, s1_wide;
  logic [15:0] s0_value, s1_value;

  modrm_dec u_modrm_dec (.*);

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // cfg order: {d, w, s, has_modrm, reg_is_opnd, has_data, data_wide_ok}
  localparam int NV = 8;
  localparam logic [46:0] VECS [NV] = '{
    {7'b1101100, 40'h000000_7F_55},
    {7'b0001100, 40'h0000_ABCD_B3},
    {7'b1101011, 40'h4433_2211_06},
    {7'b0111011, 40'h000000_81_04},
    {7'b0001011, 40'h000000_F0_C5},
    {7'b1000010, 40'h00000000_42},
    {7'b0101100, 40'h00000000_38},
    {7'b0101011, 40'h001234_FF_43}
  };

  function automatic logic [26:0] mk(logic [1:0] k, logic [2:0] r, logic h, logic w,
                                     logic [1:0] b, logic [1:0] x, logic [15:0] v);
    return {k, r, h, w, b, x, v};
  endfunction

  // R3 register naming, written as a table of names
  function automatic logic [26:0] reg_desc(logic [2:0] n, logic w);
    case ({w, n})
      4'b0000: return mk(1, 0, 0, 0, 0, 0, 0); // AL
      4'b0001: return mk(1, 1, 0, 0, 0, 0, 0); // CL
      4'b0010: return mk(1, 2, 0, 0, 0, 0, 0); // DL
      4'b0011: return mk(1, 3, 0, 0, 0, 0, 0); // BL
      4'b0100: return mk(1, 0, 1, 0, 0, 0, 0); // AH
      4'b0101: return mk(1, 1, 1, 0, 0, 0, 0); // CH
      4'b0110: return mk(1, 2, 1, 0, 0, 0, 0); // DH
      4'b0111: return mk(1, 3, 1, 0, 0, 0, 0); // BH
      default: return mk(1, n, 0, 1, 0, 0, 0); // AX..DI
    endcase
  endfunction

  function automatic logic [56:0] model(logic [6:0] c, logic [39:0] bs);
    logic d, w, s, hm, ur, hd, wok, two;
    logic [7:0] m, lo, hi;
    logic [1:0] bb, ii;
    logic [15:0] dv, iv;
    logic [26:0] a, b, rop, mop;
    int p;
    {d, w, s, hm, ur, hd, wok} = c;
    a = '0; b = '0; p = 0;
    if (hm) begin
      m = bs[7:0]; p = 1;
      rop = reg_desc(m[5:3], w);
      if (m[7:6] == 2'b11) mop = reg_desc(m[2:0], w);
      else begin
        dv = 16'h0;
        if (m[7:6] == 2'b01) begin dv = {{8{bs[15]}}, bs[15:8]}; p = 2; end
        else if (m[7:6] == 2'b10 || m[2:0] == 3'b110) begin dv = bs[23:8]; p = 3; end
        case (m[2:0])
          3'd0: begin bb = 1; ii = 1; end
          3'd1: begin bb = 1; ii = 2; end
          3'd2: begin bb = 2; ii = 1; end
          3'd3: begin bb = 2; ii = 2; end
          3'd4: begin bb = 0; ii = 1; end
          3'd5: begin bb = 0; ii = 2; end
          3'd6: begin bb = (m[7:6] == 2'b00) ? 2'd0 : 2'd2; ii = 0; end
          default: begin bb = 1; ii = 0; end
        endcase
        mop = mk(2, 0, 0, w, bb, ii, dv);
      end
      if (d) begin a = ur ? rop : '0; b = mop; end
      else   begin a = mop; b = ur ? rop : '0; end
    end
    if (hd) begin
      two = wok && w && !s;
      lo = bs[8*p +: 8];
      hi = bs[8*p+8 +: 8];
      iv = two ? {hi, lo} : (s ? {{8{lo[7]}}, lo} : {8'h00, lo});
      p = p + (two ? 2 : 1);
      if (a[26:25] == 2'd0) a = mk(3, 0, 0, two, 0, 0, iv);
      else                  b = mk(3, 0, 0, two, 0, 0, iv);
    end
    return {p[2:0], a, b};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [26:0] slot0_now();
    return {s0_kind, s0_reg, s0_hi, s0_wide, s0_base, s0_index, s0_value};
  endfunction
  function automatic logic [26:0] slot1_now();
    return {s1_kind, s1_reg, s1_hi, s1_wide, s1_base, s1_index, s1_value};
  endfunction

  task automatic send_req(logic [6:0] c);
    {req_dir, req_wide, req_sext, req_has_modrm, req_reg_is_opnd, req_has_data, req_data_wide_ok} = c;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic push(logic [7:0] b);
    in_byte = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic take_result(string tag);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk({tag, " R10 released"}, res_valid, 0);
  endtask

  task automatic run(string tag, logic [6:0] c, logic [39:0] bs, int n,
                     logic [26:0] e0, logic [26:0] e1);
    send_req(c);
    for (int k = 0; k < n; k++) push(bs[8*k +: 8]);
    chk({tag, " valid"}, res_valid, 1);
    chk({tag, " R10 len"}, res_len, n);
    chk({tag, " slot0"}, slot0_now(), e0);
    chk({tag, " slot1"}, slot1_now(), e1);
    chk({tag, " R10 in_ready low"}, in_ready, 0);
    take_result(tag);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; in_valid = 0; in_byte = 0; res_ready = 0;
    {req_dir, req_wide, req_sext, req_has_modrm, req_reg_is_opnd, req_has_data, req_data_wide_ok} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", req_ready, 1);
    chk("R1 in_ready", in_ready, 0);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 slots", {slot0_now(), slot1_now()}, 0);

    // vector table against the bench model
    for (int v = 0; v < NV; v++) begin
      logic [56:0] e;
      e = model(VECS[v][46:40], VECS[v][39:0]);
      run($sformatf("R6 R7 R8 R9 vec%0d", v), VECS[v][46:40], VECS[v][39:0],
          int'(e[56:54]), e[53:27], e[26:0]);
    end

    // R2 R3: byte registers AH (reg) and CL (rm), D=1
    run("R2 R3 byte regs", 7'b1001100, 40'hE1, 1, mk(1,0,1,0,0,0,0), mk(1,1,0,0,0,0,0));
    // R4: D=0 swaps, DI in slot0, AX in slot1
    run("R4 swap", 7'b0101100, 40'hC7, 1, mk(1,7,0,1,0,0,0), mk(1,0,0,1,0,0,0));
    // R5: direct address 0x1234, reg BX in slot0
    run("R5 direct", 7'b1101100, 40'h12341E, 3, mk(1,3,0,1,0,0,0), mk(2,0,0,1,0,0,16'h1234));
    // R6 R7: mod01 rm2 disp 0x80 -> BP+SI, FF80
    run("R6 R7 sext disp", 7'b0101100, 40'h8042, 2, mk(2,0,0,1,2,1,16'hFF80), mk(1,0,0,1,0,0,0));
    // R8: S=1 immediate FE -> FFFE, one byte
    run("R8 sext imm", 7'b0111011, 40'hFEC3, 2, mk(1,3,0,1,0,0,0), mk(3,0,0,0,0,0,16'hFFFE));
    // R9: mod10 disp then wide imm
    run("R9 order", 7'b0101011, 40'h5678010280, 5, mk(2,0,0,1,1,1,16'h0102), mk(3,0,0,1,0,0,16'h5678));
    // R11: no ModRM, one immediate byte zero-extended in slot0
    run("R11 imm only", 7'b0100010, 40'h90, 1, mk(3,0,0,0,0,0,16'h0090), 27'h0);
    // R11: nothing follows
    run("R11 empty", 7'b0000000, 40'h0, 0, 27'h0, 27'h0);

    // R10: result holds while not taken, bytes refused
    send_req(7'b1101100);
    push(8'hD8);
    in_byte = 8'hAA; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 still valid", res_valid, 1);
    chk("R10 len held", res_len, 1);
    chk("R10 slot0 held", slot0_now(), mk(1,3,0,1,0,0,0));
    chk("R10 req_ready low", req_ready, 0);
    in_valid = 1'b0;
    take_result("R10 hold");

    // R1: reset mid-instruction
    send_req(7'b0101100);
    push(8'h80);
    push(8'h11);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mid reset req_ready", req_ready, 1);
    chk("R1 mid reset in_ready", in_ready, 0);
    chk("R1 mid reset slots", {slot0_now(), slot1_now()}, 0);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10 act=hung exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule